// File: doc/BRIEF.md
# Stereo Channel Router and Rate Resampler

This block turns a buffer of stereo sample pairs into output samples at a different rate. At the start of each frame the caller gives the number of pairs in the buffer and the number of output samples wanted. A sequential divider then forms a 16.16 fixed-point step, the ratio of pairs to outputs. While the divider runs, a busy flag is high and output requests are refused.

Each accepted output request adds the step to a 16-bit fraction accumulator. The carry above bit 15 says how many pairs the source must drop after this output, and the accumulator keeps only its low 16 bits. The pair at the head of the source is routed to the two outputs according to a 4-bit mode. The mode can pass the channels straight through, swap them, copy one input channel to selected outputs, or mute both outputs. When the source buffer is empty, a request produces no valid sample and consumes nothing.

Top module: `stereoResampler`

## Requirements
- R1: After reset `outValid` is 0, `outLeft`, `outRight` and `popCnt` are 0, and `stepBusy` is 0.
- R2: Mode values 0x0, 0x6, 0x9 and 0xF mute the outputs. A served request gives `outLeft` = `outRight` = 0 with `outValid` = 1.
- R3: Mode 0x5 routes straight through: `outLeft` = `srcLeft` and `outRight` = `srcRight`.
- R4: Mode 0xA swaps the channels: `outLeft` = `srcRight` and `outRight` = `srcLeft`.
- R5: Every other mode is mono. The source is `srcRight` if mode bit 1 or bit 2 is set, and `srcLeft` otherwise. `outLeft` carries the source when mode bits 1:0 are nonzero, and 0 otherwise. `outRight` carries the source when mode bits 3:2 are nonzero, and 0 otherwise.
- R6: A `frameStart` pulse sets the step to floor(`pairCount` * 65536 / `outLen`), or to 0 when `outLen` is 0. It also clears the accumulator. `stepBusy` rises on the next cycle and stays high for exactly `CNT_W`+16 cycles.
- R7: A served request computes sum = acc + step. The outputs then show `popCnt` = floor(sum / 65536), and the accumulator becomes sum mod 65536.
- R8: A request with `srcAvail` = 0 gives `outValid` = 0, zero samples and `popCnt` = 0, and it leaves the accumulator unchanged.
- R9: A request while `stepBusy` is high, or in the cycle of `frameStart`, gives no valid output and leaves the accumulator unchanged.
- R10: `outValid`, the samples and `popCnt` appear in the cycle after the request and last one cycle. In every cycle with no served request they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Channel routing mode |
| frameStart | input | 1 | Starts the step calculation for a new frame |
| pairCount | input | CNT_W | Buffered input pairs for this frame |
| outLen | input | CNT_W | Output samples wanted for this frame |
| stepBusy | output | 1 | Step divider is running |
| outReq | input | 1 | Request for one output sample |
| srcAvail | input | 1 | Source buffer holds at least one pair |
| srcLeft | input | SMP_W | Left sample at the source head |
| srcRight | input | SMP_W | Right sample at the source head |
| outValid | output | 1 | Output sample valid, one-cycle pulse |
| outLeft | output | SMP_W | Left output sample |
| outRight | output | SMP_W | Right output sample |
| popCnt | output | CNT_W+1 | Pairs to drop from the source after this output |

## Verification
A wrong quotient bit in the divider does not show until the first requests of the frame. It then appears as a wrong `popCnt` sequence, and a low-order error can take many requests before the accumulator carries differently. For that reason, whole frames are compared request by request against a step computed in the bench. A corrupted accumulator after an empty or refused request shows at the next carry. A routing fault shows in the same cycle as the output, and every mode is swept against several sample patterns.

// File: rtl/stereoResampler_pkg.sv
package stereoResampler_pkg;

  typedef enum logic [1:0] {
    ROUTE_MUTE,
    ROUTE_STRAIGHT,
    ROUTE_CROSS,
    ROUTE_MONO
  } route_e;

  typedef struct packed {
    logic startDiv;
    logic clearAcc;
    logic advance;
  } resStrobe_t;

  function automatic route_e decodeRoute(input logic [3:0] modeIn);
    case (modeIn)
      4'h0, 4'h6, 4'h9, 4'hF: decodeRoute = ROUTE_MUTE;
      4'h5:                   decodeRoute = ROUTE_STRAIGHT;
      4'hA:                   decodeRoute = ROUTE_CROSS;
      default:                decodeRoute = ROUTE_MONO;
    endcase
  endfunction

endpackage

// File: rtl/stereoResampler_div.sv
module stereoResampler_div #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [CNT_W-1:0]          dividendInt,
  input  logic [CNT_W-1:0]          divisor,
  output logic                      busy,
  output logic [CNT_W+FRAC_W-1:0]   quotient
);
  localparam int DVD_W = CNT_W + FRAC_W;
  localparam int CNTR_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  shiftQ;
  logic [CNT_W-1:0]  remQ;
  logic [CNT_W-1:0]  dvsrQ;
  logic [CNTR_W-1:0] iterQ;
  logic              zeroDivQ;
  logic [CNT_W:0]    trial;
  logic              fits;
  logic [CNT_W:0]    trialDiff;

  assign trial     = {remQ, shiftQ[DVD_W-1]};
  assign fits      = trial >= {1'b0, dvsrQ};
  assign trialDiff = trial - {1'b0, dvsrQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '0;
      remQ     <= '0;
      dvsrQ    <= '0;
      iterQ    <= '0;
      zeroDivQ <= 1'b1;
      busy     <= 1'b0;
    end else if (start) begin
      shiftQ   <= {dividendInt, {FRAC_W{1'b0}}};
      remQ     <= '0;
      dvsrQ    <= divisor;
      iterQ    <= CNTR_W'(DVD_W);
      zeroDivQ <= (divisor == '0);
      busy     <= 1'b1;
    end else if (busy) begin
      remQ   <= fits ? trialDiff[CNT_W-1:0] : trial[CNT_W-1:0];
      shiftQ <= {shiftQ[DVD_W-2:0], fits};
      iterQ  <= iterQ - 1'b1;
      if (iterQ == CNTR_W'(1)) busy <= 1'b0;
    end
  end

  assign quotient = zeroDivQ ? '0 : shiftQ;

endmodule

// File: rtl/stereoResampler_ctrl.sv
module stereoResampler_ctrl
  import stereoResampler_pkg::*;
(
  input  logic       frameStart,
  input  logic       outReq,
  input  logic       divBusy,
  output resStrobe_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.startDiv = frameStart;
    strobes.clearAcc = frameStart;
    strobes.advance  = outReq && !divBusy && !frameStart;
  end
endmodule

// File: rtl/stereoResampler_dp.sv
module stereoResampler_dp
  import stereoResampler_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  resStrobe_t              strobes,
  input  logic [3:0]              mode,
  input  logic [CNT_W+FRAC_W-1:0] step,
  input  logic                    srcAvail,
  input  logic [SMP_W-1:0]        srcLeft,
  input  logic [SMP_W-1:0]        srcRight,
  output logic                    outValid,
  output logic [SMP_W-1:0]        outLeft,
  output logic [SMP_W-1:0]        outRight,
  output logic [CNT_W:0]          popCnt
);
  localparam int STEP_W = CNT_W + FRAC_W;
  localparam int SUM_W  = STEP_W + 1;

  logic [FRAC_W-1:0] accQ;
  logic [SUM_W-1:0]  sum;
  route_e            route;
  logic              monoRight;
  logic [SMP_W-1:0]  monoSrc;
  logic [SMP_W-1:0]  chanIn  [2];
  logic [SMP_W-1:0]  routed  [2];
  logic [1:0]        monoDest;

  assign sum       = {1'b0, step} + SUM_W'(accQ);
  assign route     = decodeRoute(mode);
  assign monoRight = mode[2] | mode[1];
  assign monoSrc   = monoRight ? srcRight : srcLeft;
  assign chanIn[0] = srcLeft;
  assign chanIn[1] = srcRight;
  assign monoDest  = {(mode[3:2] != 2'b00), (mode[1:0] != 2'b00)};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_comb begin
      case (route)
        ROUTE_STRAIGHT: routed[ch] = chanIn[ch];
        ROUTE_CROSS:    routed[ch] = chanIn[1-ch];
        ROUTE_MONO:     routed[ch] = monoDest[ch] ? monoSrc : '0;
        default:        routed[ch] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      outValid <= 1'b0;
      outLeft  <= '0;
      outRight <= '0;
      popCnt   <= '0;
    end else begin
      outValid <= 1'b0;
      outLeft  <= '0;
      outRight <= '0;
      popCnt   <= '0;
      if (strobes.clearAcc) begin
        accQ <= '0;
      end else if (strobes.advance && srcAvail) begin
        accQ     <= sum[FRAC_W-1:0];
        outValid <= 1'b1;
        outLeft  <= routed[0];
        outRight <= routed[1];
        popCnt   <= sum[SUM_W-1:FRAC_W];
      end
    end
  end

endmodule

// File: rtl/stereoResampler.sv
module stereoResampler
  import stereoResampler_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SMP_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       mode,
  input  logic             frameStart,
  input  logic [CNT_W-1:0] pairCount,
  input  logic [CNT_W-1:0] outLen,
  output logic             stepBusy,
  input  logic             outReq,
  input  logic             srcAvail,
  input  logic [SMP_W-1:0] srcLeft,
  input  logic [SMP_W-1:0] srcRight,
  output logic             outValid,
  output logic [SMP_W-1:0] outLeft,
  output logic [SMP_W-1:0] outRight,
  output logic [CNT_W:0]   popCnt
);
  localparam int STEP_W = CNT_W + FRAC_W;

  resStrobe_t        strobes;
  logic [STEP_W-1:0] step;

  stereoResampler_ctrl ctrl_i (
    .frameStart (frameStart),
    .outReq     (outReq),
    .divBusy    (stepBusy),
    .strobes    (strobes)
  );

  stereoResampler_div #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) div_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (strobes.startDiv),
    .dividendInt (pairCount),
    .divisor     (outLen),
    .busy        (stepBusy),
    .quotient    (step)
  );

  stereoResampler_dp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SMP_W(SMP_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mode     (mode),
    .step     (step),
    .srcAvail (srcAvail),
    .srcLeft  (srcLeft),
    .srcRight (srcRight),
    .outValid (outValid),
    .outLeft  (outLeft),
    .outRight (outRight),
    .popCnt   (popCnt)
  );

endmodule

// File: rtl/stereoResampler_chk.sv
module stereoResampler_chk #(
  parameter int CNT_W  = 8,
  parameter int SMP_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       mode,
  input logic             frameStart,
  input logic [CNT_W-1:0] pairCount,
  input logic [CNT_W-1:0] outLen,
  input logic             stepBusy,
  input logic             outReq,
  input logic             srcAvail,
  input logic [SMP_W-1:0] srcLeft,
  input logic [SMP_W-1:0] srcRight,
  input logic             outValid,
  input logic [SMP_W-1:0] outLeft,
  input logic [SMP_W-1:0] outRight,
  input logic [CNT_W:0]   popCnt
);
  // R10
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(outReq));

  // R8
  empty_no_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && !srcAvail) |=> (!outValid && popCnt == '0));

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && (stepBusy || frameStart)) |=> !outValid);

  // R2
  mute_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && srcAvail && !stepBusy && !frameStart &&
     (mode == 4'h0 || mode == 4'h6 || mode == 4'h9 || mode == 4'hF))
    |=> (outValid && outLeft == '0 && outRight == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (popCnt == '0 && outLeft == '0 && outRight == '0));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepBusy) |-> $past(frameStart));

endmodule

bind stereoResampler stereoResampler_chk #(.CNT_W(CNT_W), .SMP_W(SMP_W)) chk_i (.*);

// File: tb/stereoResampler_tb_top.sv
module stereoResampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int FRAC_W = 16;
  localparam int SMP_W  = 16;
  localparam int DIV_CYCLES = CNT_W + FRAC_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       mode = 4'h5;
  logic             frameStart = 1'b0;
  logic [CNT_W-1:0] pairCount = '0;
  logic [CNT_W-1:0] outLen = '0;
  logic             stepBusy;
  logic             outReq = 1'b0;
  logic             srcAvail = 1'b0;
  logic [SMP_W-1:0] srcLeft = '0;
  logic [SMP_W-1:0] srcRight = '0;
  logic             outValid;
  logic [SMP_W-1:0] outLeft;
  logic [SMP_W-1:0] outRight;
  logic [CNT_W:0]   popCnt;

  int checks = 0;
  int fails = 0;
  longint stepExp = 0;
  longint accExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereoResampler #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SMP_W(SMP_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Expected routing from R2..R5
  function automatic void expRoute(input logic [3:0] m, input longint l, input longint r,
                                   output longint eL, output longint eR);
    longint src;
    if (m == 4'h0 || m == 4'h6 || m == 4'h9 || m == 4'hF) begin eL = 0; eR = 0; end
    else if (m == 4'h5) begin eL = l; eR = r; end
    else if (m == 4'hA) begin eL = r; eR = l; end
    else begin
      src = (m[2] || m[1]) ? r : l;
      eL = (m[1:0] != 0) ? src : 0;
      eR = (m[3:2] != 0) ? src : 0;
    end
  endfunction

  task automatic startFrame(input int pc, input int ol);
    int n;
    @(negedge clk);
    pairCount = CNT_W'(pc);
    outLen = CNT_W'(ol);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    n = 0;
    while (stepBusy && n < 200) begin
      @(negedge clk);
      n++;
    end
    chkEq("R6 busy length", n, DIV_CYCLES);
    stepExp = (ol == 0) ? 0 : (longint'(pc) << FRAC_W) / ol;
    accExp = 0;
  endtask

  // one request; checks R7/R10 routing outputs after one cycle
  task automatic request(input logic [3:0] m, input int l, input int r, input bit avail,
                         input string tag);
    longint eL, eR, sum, ePop;
    @(negedge clk);
    mode = m; srcLeft = SMP_W'(l); srcRight = SMP_W'(r); srcAvail = avail; outReq = 1'b1;
    @(negedge clk);
    outReq = 1'b0;
    if (avail) begin
      expRoute(m, l & 16'hFFFF, r & 16'hFFFF, eL, eR);
      sum = accExp + stepExp;
      ePop = sum >> FRAC_W;
      accExp = sum & 64'hFFFF;
      chkEq({tag, " valid R10"}, outValid, 1);
      chkEq({tag, " left"}, outLeft, eL);
      chkEq({tag, " right"}, outRight, eR);
      chkEq({tag, " pop R7"}, popCnt, ePop);
    end else begin
      chkEq({tag, " empty valid R8"}, outValid, 0);
      chkEq({tag, " empty samples R8"}, {outLeft, outRight}, 0);
      chkEq({tag, " empty pop R8"}, popCnt, 0);
    end
    @(negedge clk);
    chkEq({tag, " pulse end R10"}, outValid, 0);
  endtask

  task automatic runFrame(input int pc, input int ol, input int nReq);
    startFrame(pc, ol);
    for (int i = 0; i < nReq; i++) request(4'h5, i * 3 + 1, i * 5 + 2, 1'b1, "R7 frame");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1 valid", outValid, 0);
    chkEq("R1 samples", {outLeft, outRight}, 0);
    chkEq("R1 pop", popCnt, 0);
    chkEq("R1 busy", stepBusy, 0);
    rstN = 1'b1;

    // R6/R7 frames of several ratios
    runFrame(10, 4, 4);
    runFrame(3, 7, 7);
    runFrame(255, 1, 1);
    runFrame(1, 255, 255);
    runFrame(200, 3, 3);
    runFrame(7, 0, 3);

    // R8 empty source mid-frame keeps accumulator
    startFrame(5, 3);
    request(4'h5, 11, 22, 1'b1, "R8 pre");
    request(4'h5, 11, 22, 1'b0, "R8 empty");
    request(4'h5, 11, 22, 1'b1, "R8 post");

    // R9 request while busy is refused, accumulator untouched
    @(negedge clk);
    pairCount = 8'd9; outLen = 8'd4; frameStart = 1'b1; outReq = 1'b1; srcAvail = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    chkEq("R9 start-cycle request", outValid, 0);
    @(negedge clk);
    chkEq("R9 busy request", outValid, 0);
    outReq = 1'b0;
    while (stepBusy) @(negedge clk);
    stepExp = (longint'(9) << FRAC_W) / 4;
    accExp = 0;
    for (int i = 0; i < 4; i++) request(4'h5, 1, 2, 1'b1, "R9 after busy");

    // R2..R5 routing sweep with step 0 (no pops)
    startFrame(0, 1);
    for (int m = 0; m < 16; m++) begin
      request(4'(m), 16'h1234, 16'hABCD, 1'b1, "R2-R5 route sweep");
      request(4'(m), 16'hFFFF, 16'h0001, 1'b1, "R3 R4 R5 R2 route");
      request(4'(m), 16'h8000, 16'h7FFF, 1'b1, "route R5 mono");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule